// File: doc/BRIEF.md
# Ethernet PAUSE Frame Detector

This block sits behind the receive side of a full-duplex Ethernet MAC. It watches the byte stream of each received frame and decides whether the frame is a MAC control PAUSE request. The MAC delivers one byte per beat, with a start marker on the first byte and an end marker on the last. A frame-good status comes with the last beat. Preamble and delimiter are already stripped. CRC checking is done upstream and only its verdict arrives here.

The header is checked as the bytes stream in. No copy of the header is buffered. Running match flags track the destination address against two references: the reserved flow-control multicast address and the station's own programmed address. A third flag tracks the type/opcode pair. The 16-bit pause quanta is captured as it passes. At the end beat the verdict is combined with the frame status and the two mode enables. A qualifying frame gives a single-cycle pulse, with the quanta value on the output bus.

Top module: `pause_detect`

## Requirements
- R1: No detect pulse is produced unless both `full_duplex` and `flow_ctl_en` are high when the end beat is sampled.
- R2: A frame whose destination bytes (byte positions 0 to 5, first byte on the wire = 0x01, then 0x80, 0xC2, 0x00, 0x00, 0x01) equal the reserved multicast address qualifies on its address.
- R3: A frame whose destination bytes equal `station_addr` qualifies on its address, with byte position 0 compared against `station_addr[47:40]` and byte position 5 against `station_addr[7:0]`.
- R4: A destination that differs from both references in any byte position 0 to 5 gives no pulse.
- R5: The bytes at positions 6 to 11 (source address) have no effect on the verdict.
- R6: Positions 12 and 13 must hold 0x88 then 0x08; any other type gives no pulse.
- R7: Positions 14 and 15 must hold 0x00 then 0x01; any other opcode gives no pulse.
- R8: Positions 16 (high byte) and 17 (low byte) form the pause quanta, any value 0x0000 to 0xFFFF. It appears on `pause_quanta` during the pulse, and `pause_quanta` is zero at all other times.
- R9: A frame whose end beat carries `rx_good` low gives no pulse.
- R10: A frame whose end beat is at a byte position below 17 gives no pulse. An end beat at position 17 or later may qualify.
- R11: The pulse is high for exactly one clock: the cycle after the clock edge that samples the end beat. Beats with `rx_valid` low are skipped and do not advance the byte position.
- R12: A beat with `rx_sof` high restarts the byte position at 0, even in the middle of a frame that has not ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Byte beat qualifier |
| rx_sof | input | 1 | First byte of a frame (with rx_valid) |
| rx_eof | input | 1 | Last byte of a frame (with rx_valid) |
| rx_data | input | 8 | Received byte |
| rx_good | input | 1 | Frame status, meaningful on the end beat |
| station_addr | input | 48 | Station unicast address, first wire byte in bits 47:40 |
| full_duplex | input | 1 | Full-duplex mode enable |
| flow_ctl_en | input | 1 | Receive flow-control enable |
| pause_hit | output | 1 | One-cycle PAUSE detect pulse |
| pause_quanta | output | 16 | Pause quanta, valid with pause_hit, zero otherwise |

## Verification
The embedded assertions check on every cycle that the following hold:
- a pulse never lasts beyond one cycle;
- a pulse only follows a sampled end beat with good status, both enables and a byte position of at least 17;
- the address and control flags freeze once their fields are past;
- a start beat resets the position.

Whether a particular byte pattern should qualify can only be shown by the bench's frames. These cover each reference address, single-byte mismatches in the address, type and opcode, varied source bytes, boundary lengths 17 and 18, extreme quanta values, an aborted frame followed by a restart, and frames sent back to back or with idle beats inside.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = ADDR_BYTES * BYTE_W;
  localparam int QUANTA_W   = 16;
  localparam int CTL_BYTES  = 4;
  localparam int CTL_W      = CTL_BYTES * BYTE_W;
  localparam int POS_W      = 5;
  localparam int NUM_REFS   = 2;

  // byte positions within the frame
  localparam logic [POS_W-1:0] POS_TYPE_HI = POS_W'(12);
  localparam logic [POS_W-1:0] POS_OP_LO   = POS_W'(15);
  localparam logic [POS_W-1:0] POS_DUR_HI  = POS_W'(16);
  localparam logic [POS_W-1:0] POS_DUR_LO  = POS_W'(17);
  localparam logic [POS_W-1:0] POS_SAT     = POS_W'(18);
  localparam logic [POS_W-1:0] POS_ADDR_END = POS_W'(ADDR_BYTES);

  localparam logic [ADDR_W-1:0] RSV_MCAST = 48'h0180_C200_0001;
  localparam logic [CTL_W-1:0]  CTL_WORD  = 32'h8808_0001;
endpackage

// File: rtl/pd_byte_pos.sv
module pd_byte_pos
  import pd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sof,
  output logic [POS_W-1:0] cur_pos
);
  logic [POS_W-1:0] pos_q, pos_d;

  always_comb begin
    cur_pos = sof ? '0 : pos_q;
    pos_d   = (cur_pos >= POS_SAT) ? POS_SAT : cur_pos + POS_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos_q <= POS_SAT;
    else if (beat) pos_q <= pos_d;
  end

  // R12: a start beat sends the next position to 1
  a_r12_sof_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && sof) |=> (pos_q == POS_W'(1)));
endmodule

// File: rtl/pd_addr_cmp.sv
module pd_addr_cmp
  import pd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [POS_W-1:0]  cur_pos,
  input  logic [BYTE_W-1:0] data,
  input  logic [ADDR_W-1:0] ref_addr,
  output logic              match
);
  logic              match_q, match_d;
  logic [BYTE_W-1:0] ref_byte;

  always_comb begin
    ref_byte = '0;
    for (int k = 0; k < ADDR_BYTES; k++) begin
      if (cur_pos == POS_W'(k)) ref_byte = ref_addr[ADDR_W-1-BYTE_W*k -: BYTE_W];
    end
    if (cur_pos == '0)              match_d = (data == ref_byte);
    else if (cur_pos < POS_ADDR_END) match_d = match_q && (data == ref_byte);
    else                            match_d = match_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    match_q <= 1'b0;
    else if (beat) match_q <= match_d;
  end

  assign match = match_q;

  // R5: bytes past the destination field leave the verdict untouched
  a_r5_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && cur_pos >= POS_ADDR_END) |=> $stable(match_q));
endmodule

// File: rtl/pd_ctl_field.sv
module pd_ctl_field
  import pd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                beat,
  input  logic [POS_W-1:0]    cur_pos,
  input  logic [BYTE_W-1:0]   data,
  output logic                ctl_ok,
  output logic [QUANTA_W-1:0] quanta_now
);
  logic                ctl_q, ctl_d;
  logic [QUANTA_W-1:0] dur_q, dur_d;
  logic [BYTE_W-1:0]   want;

  always_comb begin
    want = '0;
    for (int k = 0; k < CTL_BYTES; k++) begin
      if (cur_pos == POS_TYPE_HI + POS_W'(k)) want = CTL_WORD[CTL_W-1-BYTE_W*k -: BYTE_W];
    end
    if (cur_pos == POS_TYPE_HI)
      ctl_d = (data == want);
    else if (cur_pos > POS_TYPE_HI && cur_pos <= POS_OP_LO)
      ctl_d = ctl_q && (data == want);
    else
      ctl_d = ctl_q;

    dur_d = dur_q;
    if (cur_pos == POS_DUR_HI) dur_d = {data, dur_q[BYTE_W-1:0]};
    if (cur_pos == POS_DUR_LO) dur_d = {dur_q[QUANTA_W-1:BYTE_W], data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= 1'b0;
      dur_q <= '0;
    end else if (beat) begin
      ctl_q <= ctl_d;
      dur_q <= dur_d;
    end
  end

  assign ctl_ok     = ctl_q;
  assign quanta_now = dur_d;

  // R7: type/opcode verdict holds once position 16 is reached
  a_r7_ctl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && cur_pos >= POS_DUR_HI) |=> $stable(ctl_q));
endmodule

// File: rtl/pause_detect.sv
module pause_detect
  import pd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_valid,
  input  logic                rx_sof,
  input  logic                rx_eof,
  input  logic [7:0]          rx_data,
  input  logic                rx_good,
  input  logic [47:0]         station_addr,
  input  logic                full_duplex,
  input  logic                flow_ctl_en,
  output logic                pause_hit,
  output logic [15:0]         pause_quanta
);
  logic [POS_W-1:0]    cur_pos;
  logic [ADDR_W-1:0]   refs [NUM_REFS];
  logic [NUM_REFS-1:0] addr_hit;
  logic                ctl_ok;
  logic [QUANTA_W-1:0] quanta_now;
  logic                qualify, hit_d;
  logic [QUANTA_W-1:0] quanta_d;

  assign refs[0] = RSV_MCAST;
  assign refs[1] = station_addr;

  pd_byte_pos u_pos (
    .clk(clk), .rst_n(rst_n), .beat(rx_valid), .sof(rx_sof), .cur_pos(cur_pos)
  );

  for (genvar g = 0; g < NUM_REFS; g++) begin : g_addr
    pd_addr_cmp u_cmp (
      .clk(clk), .rst_n(rst_n), .beat(rx_valid), .cur_pos(cur_pos),
      .data(rx_data), .ref_addr(refs[g]), .match(addr_hit[g])
    );
  end

  pd_ctl_field u_ctl (
    .clk(clk), .rst_n(rst_n), .beat(rx_valid), .cur_pos(cur_pos),
    .data(rx_data), .ctl_ok(ctl_ok), .quanta_now(quanta_now)
  );

  always_comb begin
    qualify  = rx_valid && rx_eof && rx_good && full_duplex && flow_ctl_en &&
               (cur_pos >= POS_DUR_LO) && (|addr_hit) && ctl_ok;
    hit_d    = qualify;
    quanta_d = qualify ? quanta_now : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pause_hit    <= 1'b0;
      pause_quanta <= '0;
    end else begin
      pause_hit    <= hit_d;
      pause_quanta <= quanta_d;
    end
  end

  // R11: single-cycle pulse
  a_r11_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    pause_hit |=> !pause_hit);
  // R1: both enables required
  a_r1_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_duplex && flow_ctl_en) |=> !pause_hit);
  // R9: pulse follows a good end beat
  a_r9_good_end: assert property (@(posedge clk) disable iff (!rst_n)
    pause_hit |-> $past(rx_valid && rx_eof && rx_good));
  // R10: pulse needs the end beat at position 17 or later
  a_r10_min_length: assert property (@(posedge clk) disable iff (!rst_n)
    pause_hit |-> ($past(cur_pos) >= POS_DUR_LO));
endmodule

// File: tb/pause_detect_test.sv
module pause_detect_test;
  typedef struct {
    logic        hit;
    logic [15:0] q;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid, rx_sof, rx_eof, rx_good;
  logic [7:0]  rx_data;
  logic [47:0] station_addr;
  logic        full_duplex, flow_ctl_en;
  logic        pause_hit;
  logic [15:0] pause_quanta;

  int   checks = 0;
  int   fails  = 0;
  bit   started = 0;
  bit   done = 0;
  logic eof_seen;
  exp_t sb[$];
  logic [7:0] frm [0:63];

  localparam logic [47:0] MCAST = 48'h0180_C200_0001;
  localparam logic [47:0] MYMAC = 48'h0A1B_2C3D_4E5F;

  always #5 clk = ~clk;

  pause_detect uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .rx_data(rx_data), .rx_good(rx_good),
    .station_addr(station_addr), .full_duplex(full_duplex),
    .flow_ctl_en(flow_ctl_en), .pause_hit(pause_hit), .pause_quanta(pause_quanta)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: one compare per end beat, idle checks elsewhere
  always @(posedge clk) eof_seen <= rst_n && rx_valid && rx_eof;

  always @(negedge clk) begin
    if (rst_n && started) begin
      if (eof_seen) begin
        if (sb.size() == 0) begin
          check(1'b0, "R11 unexpected end beat", 32'(pause_hit), 32'h0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(pause_hit == e.hit, e.req, 32'(pause_hit), 32'(e.hit));
          check(pause_quanta == e.q, {e.req, " quanta R8"}, 32'(pause_quanta), 32'(e.q));
        end
      end else begin
        check(pause_hit == 1'b0, "R11 pulse outside end slot", 32'(pause_hit), 32'h0);
        check(pause_quanta == 16'h0, "R8 quanta idle", 32'(pause_quanta), 32'h0);
      end
    end
  end

  task automatic mk(input logic [47:0] da, input logic [47:0] sa,
                    input logic [15:0] ty, input logic [15:0] op, input logic [15:0] du);
    for (int i = 0; i < 6; i++) frm[i] = da[47-8*i -: 8];
    for (int i = 0; i < 6; i++) frm[6+i] = sa[47-8*i -: 8];
    frm[12] = ty[15:8]; frm[13] = ty[7:0];
    frm[14] = op[15:8]; frm[15] = op[7:0];
    frm[16] = du[15:8]; frm[17] = du[7:0];
    for (int i = 18; i < 64; i++) frm[i] = 8'(i * 7);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_good = 0; rx_data = 8'hxx;
    end
  endtask

  task automatic send(input int len, input bit good, input int gap_at,
                      input bit exp_hit, input logic [15:0] exp_q, input string req);
    exp_t e;
    e.hit = exp_hit; e.q = exp_hit ? exp_q : 16'h0; e.req = req;
    sb.push_back(e);
    for (int i = 0; i < len; i++) begin
      if (i == gap_at) idle(2);
      @(negedge clk);
      rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == len - 1);
      rx_good  = (i == len - 1) ? good : 1'b0;
      rx_data  = frm[i];
    end
  endtask

  task automatic send_partial(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_sof = (i == 0); rx_eof = 0; rx_good = 0; rx_data = frm[i];
    end
  endtask

  initial begin
    rst_n = 0; rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_good = 0; rx_data = 8'h00;
    station_addr = MYMAC; full_duplex = 1; flow_ctl_en = 1;
    repeat (3) @(negedge clk);
    check(pause_hit == 1'b0, "reset pause_hit", 32'(pause_hit), 32'h0);
    check(pause_quanta == 16'h0, "reset pause_quanta", 32'(pause_quanta), 32'h0);
    rst_n = 1;
    started = 1;
    idle(2);

    // R2 R8: reserved multicast, quanta 0x1234
    mk(MCAST, 48'h0011_2233_4455, 16'h8808, 16'h0001, 16'h1234);
    send(60, 1, -1, 1, 16'h1234, "R2 multicast"); idle(3);
    // R3 R8: station address, max quanta, with idle beats inside (R11)
    mk(MYMAC, 48'h0011_2233_4455, 16'h8808, 16'h0001, 16'hFFFF);
    send(64, 1, 9, 1, 16'hFFFF, "R3 station address"); idle(3);
    // R4: last address byte off
    mk(48'h0A1B_2C3D_4E5E, 48'h0, 16'h8808, 16'h0001, 16'h0042);
    send(60, 1, -1, 0, 16'h0, "R4 address mismatch last byte"); idle(3);
    // R4: first multicast byte off
    mk(48'h0380_C200_0001, 48'h0, 16'h8808, 16'h0001, 16'h0042);
    send(60, 1, -1, 0, 16'h0, "R4 address mismatch first byte"); idle(3);
    // R5: source bytes equal to the station, zero quanta still pulses
    mk(MCAST, MYMAC, 16'h8808, 16'h0001, 16'h0000);
    send(60, 1, -1, 1, 16'h0000, "R5 source ignored"); idle(3);
    mk(MYMAC, 48'hFFFF_FFFF_FFFF, 16'h8808, 16'h0001, 16'h8001);
    send(60, 1, -1, 1, 16'h8001, "R5 source all ones"); idle(3);
    // R6 / R7
    mk(MCAST, 48'h0, 16'h8809, 16'h0001, 16'h0010);
    send(60, 1, -1, 0, 16'h0, "R6 wrong type"); idle(3);
    mk(MCAST, 48'h0, 16'h0808, 16'h0001, 16'h0010);
    send(60, 1, -1, 0, 16'h0, "R6 wrong type high byte"); idle(3);
    mk(MCAST, 48'h0, 16'h8808, 16'h0002, 16'h0010);
    send(60, 1, -1, 0, 16'h0, "R7 wrong opcode"); idle(3);
    // R9
    mk(MCAST, 48'h0, 16'h8808, 16'h0001, 16'h0077);
    send(60, 0, -1, 0, 16'h0, "R9 bad status"); idle(3);
    // R10 boundaries
    send(17, 1, -1, 0, 16'h0, "R10 ends at position 16"); idle(3);
    send(18, 1, -1, 1, 16'h0077, "R10 ends at position 17"); idle(3);
    // R1 enables
    full_duplex = 0;
    send(60, 1, -1, 0, 16'h0, "R1 half duplex"); idle(3);
    full_duplex = 1; flow_ctl_en = 0;
    send(60, 1, -1, 0, 16'h0, "R1 flow control off"); idle(3);
    flow_ctl_en = 1;
    // R12: aborted frame then restart
    mk(MYMAC, 48'h0, 16'h8808, 16'h0001, 16'h0ABC);
    send_partial(14);
    send(60, 1, -1, 1, 16'h0ABC, "R12 restart on sof"); idle(3);
    // R11: back-to-back frames
    send(18, 1, -1, 1, 16'h0ABC, "R11 back to back first");
    mk(MCAST, 48'h0, 16'h8808, 16'h0001, 16'h5A5A);
    send(18, 1, -1, 1, 16'h5A5A, "R11 back to back second"); idle(5);

    check(sb.size() == 0, "R11 scoreboard drained", 32'(sb.size()), 32'h0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule